// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block turns decoded addressing-mode fields into the 32-bit linear byte offset of an operand. The caller presents a mode code, a base register value, an index register value, a two-bit scale code and a displacement with a width flag, together with a valid strobe. One clock later the block presents the summed offset, a flag that marks the operand as not residing in memory, and a matching valid strobe.

The index is multiplied by 1, 2, 4 or 8 through a left shift. A short displacement is sign-extended from its low byte. All sums wrap modulo 2^32, and no overflow is reported. Register reads, decoding, the memory access itself and any segment translation belong to neighbouring blocks.

Top module: `eag_top`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge clears `validOut`, `effAddr` and `nonMem` to zero after that edge.
- R2: `validOut` equals the `validIn` sampled at the previous rising edge, provided `rst` was low at that edge.
- R3: Mode codes are 0=immediate, 1=direct, 2=register, 3=register indirect, 4=base+disp, 5=index*scale+disp, 6=base+index*scale and 7=base+index*scale+disp. The address is the sum of exactly the terms that the mode names.
- R4: `scaleCode` is a left-shift amount for the index: 0 gives x1, 1 gives x2, 2 gives x4 and 3 gives x8. For example, base 1000, index 40, code 2 and displacement 200 in mode 7 give 1360.
- R5: When `dispWide`=0 in modes 4, 5 and 7, the displacement is `dispVal[7:0]` sign-extended to 32 bits, and `dispVal[31:8]` has no effect. When `dispWide`=1, all 32 bits are used.
- R6: All additions and the scale shift wrap modulo 2^32. Bits shifted out of the index are lost.
- R7: Modes 0 and 2 set `nonMem`=1 and give `effAddr`=0. All other modes set `nonMem`=0.
- R8: In direct mode (1), the address is the full 32-bit `dispVal` whatever `dispWide` is. In register-indirect mode (3), the address is `baseVal` alone.
- R9: After an edge at which `validIn` is low, `effAddr` and `nonMem` keep their previous values whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Fields are valid this cycle |
| mode | input | 3 | Addressing mode code |
| baseVal | input | 32 | Base register value |
| indexVal | input | 32 | Index register value |
| scaleCode | input | 2 | Index shift amount |
| dispVal | input | 32 | Displacement |
| dispWide | input | 1 | 1: 32-bit displacement, 0: sign-extended low byte |
| validOut | output | 1 | Result valid |
| effAddr | output | 32 | Effective address |
| nonMem | output | 1 | Operand is immediate or register |

## Verification
The bench builds the block with its default parameters: a 32-bit address, an 8-bit short displacement and a 2-bit scale code. With these values, every mode and every shift amount can be reached, and so can sign extension of negative short displacements with garbage in the upper bits. Wrap-around can be reached both through the shifted-out index bits and through carries past bit 31.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [2:0] {
    MODE_IMM       = 3'd0,
    MODE_DIRECT    = 3'd1,
    MODE_REG       = 3'd2,
    MODE_REGIND    = 3'd3,
    MODE_BASE_DISP = 3'd4,
    MODE_IDX_DISP  = 3'd5,
    MODE_BASE_IDX  = 3'd6,
    MODE_FULL      = 3'd7
  } addrMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic useBase;
    logic useIndex;
    logic useDisp;
    logic forceWide;
    logic nonMem;
  } eagCtrl_t;

endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       validIn,
  input  logic [2:0] mode,
  output eagCtrl_t   ctrl,
  output logic       validOut
);

  addrMode_t modeCode;
  assign modeCode = addrMode_t'(mode);

  always_comb begin
    ctrl = '0;
    ctrl.load = validIn;
    unique case (modeCode)
      MODE_IMM:       ctrl.nonMem = 1'b1;
      MODE_DIRECT:    begin ctrl.useDisp = 1'b1; ctrl.forceWide = 1'b1; end
      MODE_REG:       ctrl.nonMem = 1'b1;
      MODE_REGIND:    ctrl.useBase = 1'b1;
      MODE_BASE_DISP: begin ctrl.useBase = 1'b1; ctrl.useDisp = 1'b1; end
      MODE_IDX_DISP:  begin ctrl.useIndex = 1'b1; ctrl.useDisp = 1'b1; end
      MODE_BASE_IDX:  begin ctrl.useBase = 1'b1; ctrl.useIndex = 1'b1; end
      MODE_FULL:      begin ctrl.useBase = 1'b1; ctrl.useIndex = 1'b1; ctrl.useDisp = 1'b1; end
      default:        ctrl.nonMem = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= validIn;
  end

endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DISP_SHORT_W = 8,
  parameter int SCALE_W      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  eagCtrl_t           ctrl,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic [ADDR_W-1:0]  indexVal,
  input  logic [SCALE_W-1:0] scaleCode,
  input  logic [ADDR_W-1:0]  dispVal,
  input  logic               dispWide,
  output logic [ADDR_W-1:0]  effAddr,
  output logic               nonMem
);

  localparam int EXT_W = ADDR_W - DISP_SHORT_W;

  logic [ADDR_W-1:0] dispShort;
  logic [ADDR_W-1:0] dispTerm;
  logic [ADDR_W-1:0] baseTerm;
  logic [ADDR_W-1:0] indexTerm;
  logic [ADDR_W-1:0] sumNext;

  // short displacement sign-extended from its top bit
  generate
    if (EXT_W > 0) begin : g_ext
      assign dispShort = {{EXT_W{dispVal[DISP_SHORT_W-1]}}, dispVal[DISP_SHORT_W-1:0]};
    end else begin : g_noext
      assign dispShort = dispVal;
    end
  endgenerate

  always_comb begin
    baseTerm  = ctrl.useBase  ? baseVal : '0;
    indexTerm = ctrl.useIndex ? (indexVal << scaleCode) : '0;
    if (!ctrl.useDisp)                    dispTerm = '0;
    else if (dispWide || ctrl.forceWide)  dispTerm = dispVal;
    else                                  dispTerm = dispShort;
    sumNext = baseTerm + indexTerm + dispTerm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      effAddr <= '0;
      nonMem  <= 1'b0;
    end else if (ctrl.load) begin
      effAddr <= ctrl.nonMem ? '0 : sumNext;
      nonMem  <= ctrl.nonMem;
    end
  end

endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DISP_SHORT_W = 8,
  parameter int SCALE_W      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               validIn,
  input  logic [2:0]         mode,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic [ADDR_W-1:0]  indexVal,
  input  logic [SCALE_W-1:0] scaleCode,
  input  logic [ADDR_W-1:0]  dispVal,
  input  logic               dispWide,
  output logic               validOut,
  output logic [ADDR_W-1:0]  effAddr,
  output logic               nonMem
);

  eagCtrl_t ctrl;

  eag_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .mode     (mode),
    .ctrl     (ctrl),
    .validOut (validOut)
  );

  eag_datapath #(
    .ADDR_W       (ADDR_W),
    .DISP_SHORT_W (DISP_SHORT_W),
    .SCALE_W      (SCALE_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .baseVal   (baseVal),
    .indexVal  (indexVal),
    .scaleCode (scaleCode),
    .dispVal   (dispVal),
    .dispWide  (dispWide),
    .effAddr   (effAddr),
    .nonMem    (nonMem)
  );

endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              validIn,
  input logic [2:0]        mode,
  input logic [ADDR_W-1:0] baseVal,
  input logic              validOut,
  input logic [ADDR_W-1:0] effAddr,
  input logic              nonMem
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!validOut && !nonMem && effAddr == '0)); // R1
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) validIn |=> validOut); // R2
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst) !validIn |=> !validOut); // R2
  AST_NONMEM_ZERO: assert property (@(posedge clk) disable iff (rst) nonMem |-> effAddr == '0); // R7
  AST_NONMEM_MODES: assert property (@(posedge clk) disable iff (rst)
    (validIn && (mode == 3'd0 || mode == 3'd2)) |=> nonMem); // R7
  AST_REGIND_BASE: assert property (@(posedge clk) disable iff (rst)
    (validIn && mode == 3'd3) |=> (effAddr == $past(baseVal) && !nonMem)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> ($stable(effAddr) && $stable(nonMem))); // R9

endmodule

bind eag_top eag_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .validIn  (validIn),
  .mode     (mode),
  .baseVal  (baseVal),
  .validOut (validOut),
  .effAddr  (effAddr),
  .nonMem   (nonMem)
);

// File: tb/tb_eag_top.sv
`timescale 1ns/1ps
module tb_eag_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        validIn;
  logic [2:0]  mode;
  logic [31:0] baseVal, indexVal, dispVal;
  logic [1:0]  scaleCode;
  logic        dispWide;
  logic        validOut;
  logic [31:0] effAddr;
  logic        nonMem;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  eag_top dut (
    .clk(clk), .rst(rst), .validIn(validIn), .mode(mode),
    .baseVal(baseVal), .indexVal(indexVal), .scaleCode(scaleCode),
    .dispVal(dispVal), .dispWide(dispWide),
    .validOut(validOut), .effAddr(effAddr), .nonMem(nonMem)
  );

  function automatic logic [31:0] modelAddr(logic [2:0] m, logic [31:0] b, logic [31:0] ix,
                                            logic [1:0] sc, logic [31:0] d, logic w);
    logic [31:0] dx, sx;
    dx = w ? d : {{24{d[7]}}, d[7:0]};
    sx = ix << sc;
    case (m)
      3'd1: return d;
      3'd3: return b;
      3'd4: return b + dx;
      3'd5: return sx + dx;
      3'd6: return b + sx;
      3'd7: return b + sx + dx;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic modelNonMem(logic [2:0] m);
    return (m == 3'd0 || m == 3'd2);
  endfunction

  task automatic check(string req, logic [31:0] gotA, logic [31:0] expA,
                       logic gotN, logic expN, logic gotV, logic expV);
    checks++;
    if (gotA !== expA || gotN !== expN || gotV !== expV) begin
      fails++;
      $display("FAIL %s: addr=%h nonMem=%b valid=%b expected addr=%h nonMem=%b valid=%b",
               req, gotA, gotN, gotV, expA, expN, expV);
    end
  endtask

  // apply one valid vector and check the registered result
  task automatic apply(string req, logic [2:0] m, logic [31:0] b, logic [31:0] ix,
                       logic [1:0] sc, logic [31:0] d, logic w);
    @(negedge clk);
    validIn = 1'b1; mode = m; baseVal = b; indexVal = ix;
    scaleCode = sc; dispVal = d; dispWide = w;
    @(posedge clk);
    @(negedge clk);
    check(req, effAddr, modelAddr(m, b, ix, sc, d, w), nonMem, modelNonMem(m), validOut, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] prevA;
    logic        prevN;
    void'($urandom(32'd1211));
    rst = 1'b1; validIn = 1'b1; mode = 3'd7; baseVal = 32'hFFFF_FFFF;
    indexVal = 32'h1; scaleCode = 2'd1; dispVal = 32'h5; dispWide = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", effAddr, 32'd0, nonMem, 1'b0, validOut, 1'b0);
    rst = 1'b0; validIn = 1'b0;

    apply("R4 example", 3'd7, 32'd1000, 32'd40, 2'd2, 32'd200, 1'b1);
    apply("R4 scale x1", 3'd6, 32'd100, 32'd7, 2'd0, 32'd0, 1'b0);
    apply("R4 scale x8", 3'd5, 32'd0, 32'd7, 2'd3, 32'd3, 1'b1);
    apply("R5 short negative", 3'd4, 32'd1000, 32'd0, 2'd0, 32'hABCD_12F0, 1'b0);
    apply("R5 short positive", 3'd7, 32'd10, 32'd2, 2'd1, 32'hFFFF_FF7F, 1'b0);
    apply("R6 index shift wrap", 3'd6, 32'd5, 32'h2000_0001, 2'd3, 32'd0, 1'b0);
    apply("R6 carry wrap", 3'd4, 32'hFFFF_FFFF, 32'd0, 2'd0, 32'd2, 1'b1);
    apply("R7 immediate", 3'd0, 32'h1234, 32'h55, 2'd2, 32'h99, 1'b1);
    apply("R7 register", 3'd2, 32'h1234, 32'h55, 2'd2, 32'h99, 1'b0);
    apply("R8 direct narrow flag", 3'd1, 32'h77, 32'h1, 2'd3, 32'hDEAD_00F0, 1'b0);
    apply("R8 register indirect", 3'd3, 32'hCAFE_0001, 32'h1, 2'd3, 32'h40, 1'b1);

    // R9: hold with validIn low, R2: validOut drops
    @(negedge clk);
    prevA = effAddr; prevN = nonMem;
    validIn = 1'b0; mode = 3'd7; baseVal = 32'h1111; indexVal = 32'h2222; dispVal = 32'h3;
    @(posedge clk); @(negedge clk);
    check("R9 hold idle", effAddr, prevA, nonMem, prevN, validOut, 1'b0);
    mode = 3'd0;
    @(posedge clk); @(negedge clk);
    check("R2 R9 second idle", effAddr, prevA, nonMem, prevN, validOut, 1'b0);

    // R3 constrained random over all modes
    for (int i = 0; i < 400; i++) begin
      logic [2:0] m;
      logic [31:0] b, ix, d;
      logic [1:0] sc;
      logic w;
      m = 3'($urandom_range(0, 7));
      b = $urandom; ix = $urandom; d = $urandom;
      sc = 2'($urandom_range(0, 3)); w = 1'($urandom_range(0, 1));
      if (i % 5 == 0) ix = ix & 32'hFF;
      apply("R3 random mode", m, b, ix, sc, d, w);
    end

    // R1 reset mid-stream
    @(negedge clk);
    rst = 1'b1; validIn = 1'b1; mode = 3'd4;
    @(posedge clk); @(negedge clk);
    check("R1 reset mid-stream", effAddr, 32'd0, nonMem, 1'b0, validOut, 1'b0);
    rst = 1'b0; validIn = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule